// File: doc/BRIEF.md
# Extended-Nonce Subkey Derivation Unit

This unit turns a 256-bit key and a 128-bit nonce into a 256-bit subkey. It uses the ChaCha20 permutation, but it does not add the input state back after the rounds. A pulse on `start` while the unit is idle latches `key` and `nonce` into a sixteen-word working state. The rounds then run over the following cycles, and the unit answers with a one-cycle `done` pulse. From that pulse onward, `subkey` carries the result.

The subkey stays on the port until the next accepted start. A cipher wrapper can therefore read it at leisure and feed it into a later ChaCha20 key schedule. No block counter exists: the same key and nonce always produce the same subkey.

The `ROUNDS_PER_CYCLE` parameter sets how many rounds are chained in one clock. This trades latency against combinational depth.

Top module: `subkey_deriver`

## Requirements
- R1: During and after a synchronous active-low reset, `busy` and `done` are low and `subkey` is all zeros.
- R2: A `start` sampled high while `busy` is low latches `key` and `nonce` and raises `busy` on the next cycle. Later changes to `key` or `nonce` do not alter the result.
- R3: The working state is built as follows:
  - Words 0 to 3 are the constants 0x61707865, 0x3320646e, 0x79622d32 and 0x6b206574.
  - Word 4+j is `key[32*j+31:32*j]` for j = 0..7, which is little-endian with key byte i at `key[8*i+7:8*i]`.
  - Word 12+j is `nonce[32*j+31:32*j]` for j = 0..3.
- R4: Twenty rounds are applied in order column, diagonal, column, and so on. Each round is four quarter rounds using add, xor and left rotations by 16, 12, 8 and 7. Column rounds act on word sets {i, 4+i, 8+i, 12+i}. Diagonal rounds act on {i, 4+(i+1)%4, 8+(i+2)%4, 12+(i+3)%4}.
- R5: No addition of the initial state follows the rounds.
- R6: `subkey[32*k+31:32*k]` is final word k for k = 0..3, and final word 8+k for k = 4..7.
- R7: `done` is high for exactly one cycle. It occurs 20/ROUNDS_PER_CYCLE cycles after the accepting edge, and `busy` stays high on every cycle in between.
- R8: A `start` sampled while `busy` is high is ignored. This includes the final working cycle, and it affects neither the timing nor the result.
- R9: `subkey` holds its value from `done` until the next accepted start. Repeating the same inputs yields the same subkey.
- R10: `busy` falls in the same cycle that `done` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a derivation; accepted only when idle |
| key | input | 256 | Input key, byte i in bits 8i+7..8i |
| nonce | input | 128 | Input nonce, byte i in bits 8i+7..8i |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle pulse when the subkey is ready |
| subkey | output | 256 | Derived subkey, byte i in bits 8i+7..8i |

## Verification
The hardest situation to reach from the ports is a start request landing exactly on the last working cycle. At that point `busy` is still high, so the request must be dropped, but an off-by-one in the step counter would accept it. The bench raises `start` during the middle of a run and again just before the final round edge. In both cases it scrambles `key` and `nonce` at the same moment, so any wrongly accepted request or late capture shows up as a wrong subkey or a shifted `done`.

// File: rtl/skd_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, state types, the sigma constants and the quarter-round function.
// Assumes 32-bit words and a sixteen-word permutation state.
package skd_pkg;
    localparam int WORD_W      = 32;
    localparam int NUM_WORDS   = 16;
    localparam int KEY_WORDS   = 8;
    localparam int NONCE_WORDS = 4;
    localparam int LANES       = 4;
    localparam int KEY_W       = KEY_WORDS * WORD_W;
    localparam int NONCE_W     = NONCE_WORDS * WORD_W;
    localparam int OUT_WORDS   = 8;
    localparam int OUT_W       = OUT_WORDS * WORD_W;

    typedef logic [WORD_W-1:0]                 word_t;
    typedef logic [NUM_WORDS-1:0][WORD_W-1:0]  state_t;
    typedef logic [LANES-1:0][WORD_W-1:0]      quad_t;

    // Constant words placed in state positions 0..3 (index 0 is the lowest entry).
    localparam quad_t SIGMA = {32'h6b206574, 32'h79622d32, 32'h3320646e, 32'h61707865};

    // Left rotation by a fixed amount.
    function automatic word_t rotl(input word_t x, input int unsigned n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    // One quarter round on (a,b,c,d) = (q[0],q[1],q[2],q[3]).
    function automatic quad_t quarter(input quad_t q);
        word_t a, b, c, d;
        a = q[0]; b = q[1]; c = q[2]; d = q[3];
        a = a + b; d = rotl(d ^ a, 16);
        c = c + d; b = rotl(b ^ c, 12);
        a = a + b; d = rotl(d ^ a, 8);
        c = c + d; b = rotl(b ^ c, 7);
        return {d, c, b, a};
    endfunction
endpackage

// File: rtl/skd_state_init.sv
`timescale 1ns/1ps
// Module: skd_state_init
// Builds the sixteen-word starting state from the constants, the key and the nonce.
// Assumes key and nonce are already little-endian packed, byte 0 in the low bits.
module skd_state_init
    import skd_pkg::*;
(
    input  logic [KEY_W-1:0]   key_i,
    input  logic [NONCE_W-1:0] nonce_i,
    output state_t             state_o
);
    genvar gi;
    generate
        // Constant words in positions 0..3.
        for (gi = 0; gi < LANES; gi++) begin : g_const
            assign state_o[gi] = SIGMA[gi];
        end
        // Key words in positions 4..11.
        for (gi = 0; gi < KEY_WORDS; gi++) begin : g_key
            assign state_o[LANES + gi] = key_i[gi*WORD_W +: WORD_W];
        end
        // Nonce words in positions 12..15.
        for (gi = 0; gi < NONCE_WORDS; gi++) begin : g_nonce
            assign state_o[LANES + KEY_WORDS + gi] = nonce_i[gi*WORD_W +: WORD_W];
        end
    endgenerate
endmodule

// File: rtl/skd_round.sv
`timescale 1ns/1ps
// Module: skd_round
// One combinational round: four quarter-round lanes that are shared by column and
// diagonal rounds through input and output steering.
// Assumes diag_i selects the diagonal pattern; otherwise a column round is applied.
module skd_round
    import skd_pkg::*;
(
    input  state_t st_i,
    input  logic   diag_i,
    output state_t st_o
);
    // qin[lane][group]: operand of group g (a,b,c,d) for a lane.
    logic [LANES-1:0][LANES-1:0][WORD_W-1:0] qin;
    logic [LANES-1:0][LANES-1:0][WORD_W-1:0] qout;

    genvar ln, gr, ps;
    generate
        for (ln = 0; ln < LANES; ln++) begin : g_lane
            for (gr = 0; gr < LANES; gr++) begin : g_in
                localparam int COL_IDX  = LANES*gr + ln;
                localparam int DIAG_IDX = LANES*gr + ((ln + gr) % LANES);
                // Steer the operand for this lane and group.
                assign qin[ln][gr] = diag_i ? st_i[DIAG_IDX] : st_i[COL_IDX];
            end
            // Quarter-round datapath for this lane.
            assign qout[ln] = quarter(qin[ln]);
        end
        for (gr = 0; gr < LANES; gr++) begin : g_out_grp
            for (ps = 0; ps < LANES; ps++) begin : g_out_pos
                localparam int DIAG_LANE = (ps + LANES - gr) % LANES;
                // Route each result back to the word it was read from.
                assign st_o[LANES*gr + ps] = diag_i ? qout[DIAG_LANE][gr] : qout[ps][gr];
            end
        end
    endgenerate
endmodule

// File: rtl/skd_ctrl.sv
`timescale 1ns/1ps
// Module: skd_ctrl
// Sequencer: accepts start when idle, counts round steps, pulses done after the last.
// Assumes STEPS >= 1 and that each step applies RPC consecutive rounds.
module skd_ctrl #(
    parameter int STEPS = 20,
    parameter int RPC   = 1,
    parameter int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    output logic           busy_o,
    output logic           done_o,
    output logic           load_o,
    output logic           adv_o,
    output logic [RPC-1:0] diag_o
);
    logic             run_q;
    logic [CNT_W-1:0] step_q;

    // Run flag, step counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            step_q <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (!run_q) begin
                if (start_i) begin
                    run_q  <= 1'b1;
                    step_q <= '0;
                end
            end else if (step_q == CNT_W'(STEPS - 1)) begin
                run_q  <= 1'b0;
                step_q <= '0;
                done_o <= 1'b1;
            end else begin
                step_q <= step_q + 1'b1;
            end
        end
    end

    assign busy_o = run_q;
    assign load_o = start_i & ~run_q;
    assign adv_o  = run_q;

    genvar gi;
    generate
        for (gi = 0; gi < RPC; gi++) begin : g_diag
            if (RPC % 2 == 0) begin : g_even
                // Even rounds per step: pattern fixed by position in the chain.
                assign diag_o[gi] = (gi % 2) == 1;
            end else begin : g_odd
                // Odd rounds per step: pattern alternates with the step parity.
                assign diag_o[gi] = step_q[0] ^ ((gi % 2) == 1);
            end
        end
    endgenerate
endmodule

// File: rtl/subkey_deriver.sv
`timescale 1ns/1ps
// Module: subkey_deriver (top)
// Derives a 256-bit subkey from key and nonce with the ChaCha20 permutation and no
// feed-forward. Output words are final state words 0..3 then 12..15.
// Assumes ROUNDS is a multiple of ROUNDS_PER_CYCLE.
module subkey_deriver
    import skd_pkg::*;
#(
    parameter int ROUNDS           = 20,
    parameter int ROUNDS_PER_CYCLE = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [KEY_W-1:0]   key,
    input  logic [NONCE_W-1:0] nonce,
    output logic               busy,
    output logic               done,
    output logic [OUT_W-1:0]   subkey
);
    localparam int STEPS = ROUNDS / ROUNDS_PER_CYCLE;
    localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam int HALF  = OUT_WORDS / 2;

    state_t                       st_q;
    state_t                       init_w;
    state_t                       chain [ROUNDS_PER_CYCLE+1];
    logic                         load_w;
    logic                         adv_w;
    logic [ROUNDS_PER_CYCLE-1:0]  diag_w;

    skd_state_init u_init (
        .key_i   (key),
        .nonce_i (nonce),
        .state_o (init_w)
    );

    skd_ctrl #(
        .STEPS (STEPS),
        .RPC   (ROUNDS_PER_CYCLE),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .busy_o  (busy),
        .done_o  (done),
        .load_o  (load_w),
        .adv_o   (adv_w),
        .diag_o  (diag_w)
    );

    assign chain[0] = st_q;

    genvar gi;
    generate
        for (gi = 0; gi < ROUNDS_PER_CYCLE; gi++) begin : g_core
            skd_round u_round (
                .st_i   (chain[gi]),
                .diag_i (diag_w[gi]),
                .st_o   (chain[gi+1])
            );
        end
    endgenerate

    // Working state: load on accepted start, advance while running, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (load_w) begin
            st_q <= init_w;
        end else if (adv_w) begin
            st_q <= chain[ROUNDS_PER_CYCLE];
        end
    end

    generate
        for (gi = 0; gi < HALF; gi++) begin : g_out
            // Low half from words 0..3, high half from words 12..15.
            assign subkey[gi*WORD_W +: WORD_W]        = st_q[gi];
            assign subkey[(gi+HALF)*WORD_W +: WORD_W] = st_q[NUM_WORDS - HALF + gi];
        end
    endgenerate
endmodule

// File: rtl/subkey_deriver_chk.sv
`timescale 1ns/1ps
// Module: subkey_deriver_chk
// Protocol checker for subkey_deriver, attached by bind. Counts busy cycles to check
// the run length without deep $past windows.
module subkey_deriver_chk #(
    parameter int STEPS = 20,
    parameter int OUT_W = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [OUT_W-1:0] subkey
);
    logic [31:0] run_len;

    // Length of the current or just-ended busy stretch.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_run_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len == 32'(STEPS)));

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(subkey));

    assert_busy_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    assert_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && run_len < 32'(STEPS - 1)) |=> busy);
endmodule

bind subkey_deriver subkey_deriver_chk #(
    .STEPS (STEPS),
    .OUT_W (skd_pkg::OUT_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .subkey (subkey)
);

// File: tb/subkey_deriver_bench.sv
`timescale 1ns/1ps
// Bench for subkey_deriver: seeded random and directed inputs against a procedural model.
module subkey_deriver_bench;
    localparam int STEPS = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [255:0] key = '0;
    logic [127:0] nonce = '0;
    logic         busy;
    logic         done;
    logic [255:0] subkey;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    subkey_deriver u_subkey_deriver (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .key    (key),
        .nonce  (nonce),
        .busy   (busy),
        .done   (done),
        .subkey (subkey)
    );

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    // Quarter round, returned as {d,c,b,a}.
    function automatic logic [127:0] mqr(input logic [31:0] a, b, c, d);
        a += b; d ^= a; d = rl(d, 16);
        c += d; b ^= c; b = rl(b, 12);
        a += b; d ^= a; d = rl(d, 8);
        c += d; b ^= c; b = rl(b, 7);
        return {d, c, b, a};
    endfunction

    // Expected subkey from R3..R6.
    function automatic logic [255:0] model(input logic [255:0] k, input logic [127:0] n);
        logic [31:0] x [16];
        x[0] = 32'h61707865; x[1] = 32'h3320646e; x[2] = 32'h79622d32; x[3] = 32'h6b206574;
        for (int i = 0; i < 8; i++) x[4+i]  = k[32*i +: 32];
        for (int i = 0; i < 4; i++) x[12+i] = n[32*i +: 32];
        for (int r = 0; r < 10; r++) begin
            {x[12], x[8],  x[4], x[0]} = mqr(x[0], x[4], x[8],  x[12]);
            {x[13], x[9],  x[5], x[1]} = mqr(x[1], x[5], x[9],  x[13]);
            {x[14], x[10], x[6], x[2]} = mqr(x[2], x[6], x[10], x[14]);
            {x[15], x[11], x[7], x[3]} = mqr(x[3], x[7], x[11], x[15]);
            {x[15], x[10], x[5], x[0]} = mqr(x[0], x[5], x[10], x[15]);
            {x[12], x[11], x[6], x[1]} = mqr(x[1], x[6], x[11], x[12]);
            {x[13], x[8],  x[7], x[2]} = mqr(x[2], x[7], x[8],  x[13]);
            {x[14], x[9],  x[4], x[3]} = mqr(x[3], x[4], x[9],  x[14]);
        end
        return {x[15], x[14], x[13], x[12], x[3], x[2], x[1], x[0]};
    endfunction

    function automatic logic [255:0] rnd256();
        return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One derivation; mode 0 plain, 1 start and input change mid-run, 2 start on the last cycle.
    task automatic run_one(input logic [255:0] k, input logic [127:0] n, input int mode);
        logic [255:0] exp;
        bit timing_ok;
        exp = model(k, n);
        timing_ok = 1'b1;
        @(negedge clk);
        key = k; nonce = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1 && done == 1'b0, "R2", "busy after accept", {255'd0, busy}, 256'd1);
        for (int cyc = 1; cyc <= STEPS; cyc++) begin
            if (mode == 1 && cyc == 5) begin
                start = 1'b1; key = rnd256(); nonce = rnd256()[127:0];
            end
            if (mode == 2 && cyc == STEPS) begin
                start = 1'b1; key = ~k; nonce = ~n;
            end
            @(negedge clk);
            start = 1'b0;
            if (cyc < STEPS && (done || !busy)) timing_ok = 1'b0;
        end
        check(timing_ok, "R7", "busy held, no early done", {254'd0, busy, done}, 256'd2);
        check(done == 1'b1, "R7", "done after 20 cycles", {255'd0, done}, 256'd1);
        check(busy == 1'b0, "R10", "busy low with done", {255'd0, busy}, 256'd0);
        check(subkey === exp, (mode == 0) ? "R4 R5 R6" : "R8", "subkey", subkey, exp);
        key = rnd256(); nonce = rnd256()[127:0];
        @(negedge clk);
        check(done == 1'b0, "R7", "done single pulse", {255'd0, done}, 256'd0);
        check(busy == 1'b0, "R8", "no restart after ignored start", {255'd0, busy}, 256'd0);
        repeat (3) @(negedge clk);
        check(subkey === exp, "R9", "subkey held while idle", subkey, exp);
    endtask

    initial begin
        logic [255:0] k;
        logic [255:0] first;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state.
        check(busy == 1'b0 && done == 1'b0, "R1", "flags in reset", {254'd0, busy, done}, 256'd0);
        check(subkey === 256'd0, "R1", "subkey in reset", subkey, 256'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(subkey === 256'd0 && !busy, "R1", "after reset", subkey, 256'd0);

        // Directed corner inputs (R3 layout extremes).
        run_one(256'd0, 128'd0, 0);
        run_one({256{1'b1}}, {128{1'b1}}, 0);
        for (int i = 0; i < 32; i++) k[8*i +: 8] = 8'(i);
        run_one(k, 128'h27594131_00000000_4a000000_09000000, 0);
        run_one(256'd1, 128'd0, 0);          // R3: key byte 0 lands in word 4 low bits
        run_one(256'd0, 128'd1 << 127, 0);   // R3: top nonce bit

        // R9: repeat identical inputs.
        run_one(k, 128'h1, 0);
        first = subkey;
        run_one(k, 128'h1, 0);
        check(subkey === first, "R9", "repeat identical", subkey, first);

        // R2, R8: disturbances mid-run and on the last working cycle.
        run_one(rnd256(), rnd256()[127:0], 1);
        run_one(rnd256(), rnd256()[127:0], 2);

        // Random inputs.
        for (int t = 0; t < 20; t++) run_one(rnd256(), rnd256()[127:0], t % 3);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule